// File: doc/BRIEF.md
# Downstream Port Remapper

This block turns a hub's logical downstream port numbers, the ones the host enumerates, into indices of its physical downstream ports, and back again. Configuration supplies a per-port disable mask and an ordering table. Each ordering slot names one physical port. The block walks the slots in turn and skips every physical port that is disabled. It gives each surviving port the next logical number, starting at 1. Whatever the disables are, the host therefore always sees ports numbered 1 to N with no gaps.

A port counts as disabled if its register disable bit is set or if its hardware strap was found active. Straps are sampled once, at the first clock edge after reset is released. Only the lower physical ports have a strap input; the parameter STRAP_PORTS sets how many. Configuration inputs are registered on every clock. All lookups are combinational from those registers, so a new setting shows at the outputs one edge after it is driven. If the ordering table is not a permutation of the physical ports, the block uses identity order and raises an error flag.

Top module: `port_remap_top`

## Requirements
- R1: While reset is asserted, the block is in its reset state: identity ordering, no port disabled, active_count equal to NUM_PORTS, config_error low, and every logical and physical lookup valid and equal to its own index plus 1.
- R2: A change on cfg_dis or cfg_order leaves the outputs unchanged until the next rising clock edge, and is fully visible after that edge.
- R3: Ordering slot k, a field of IDX_W bits at cfg_order[k], holds a physical port number from 1 to NUM_PORTS. Enabled ports receive logical numbers 1, 2, ... in increasing slot order. active_count equals the number of enabled ports. Bit L of l2p_valid is set exactly when L is less than active_count.
- R4: For every valid logical entry L, l2p_phys[L] holds the physical port number, and p2l_log at that physical port holds L+1. The lookup for a disabled physical port, and for a logical entry at or beyond active_count, reads 0 and is not valid.
- R5: If any slot holds 0, a value above NUM_PORTS, or a value that an earlier slot already holds, the block raises config_error and uses identity ordering (slot k means physical port k+1). Disables still apply to that fallback order.
- R6: The effective disable of a port is the OR of its register bit (cfg_dis bit p, for physical port p+1) and its sampled strap.
- R7: strap_dis is sampled only at the first rising edge after reset is released. Later changes on it have no effect until the next reset.
- R8: A strap bit at or above STRAP_PORTS (physical port 3 in the default configuration) is ignored.
- R9: With every port disabled, active_count is 0 and no lookup is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_dis | input | NUM_PORTS | Hardware strap disables, bit p for physical port p+1 |
| cfg_dis | input | NUM_PORTS | Register disables, bit p for physical port p+1 |
| cfg_order | input | NUM_PORTS x IDX_W | Ordering table; slot k holds a physical port number |
| l2p_phys | output | NUM_PORTS x IDX_W | Physical port number for logical port L+1, 0 if unused |
| l2p_valid | output | NUM_PORTS | Logical entry L is in use |
| p2l_log | output | NUM_PORTS x IDX_W | Logical number of physical port p+1, 0 if disabled |
| p2l_valid | output | NUM_PORTS | Physical port p+1 is enabled |
| active_count | output | IDX_W | Number of enabled ports reported to the host |
| config_error | output | 1 | Ordering table is not a permutation; identity in use |

## Verification
Two functions can act in the same cycle: the identity fallback for an illegal ordering, and the repacking around a disabled port. The bench drives them together in one edge. It loads a table with a zero slot at the same time as it disables physical port 3. The result must show config_error set, identity order, and port 3 dropped, so that logical 1 and 2 map to physical 1 and 2 and the count is 2. A second case lands on the edge just after reset: strap sampling and register disables meet there, and the bench checks that the strap bit for port 3 drops out while the OR with the register bits still applies.

// File: rtl/prm_pkg.sv
package prm_pkg;
   localparam int unsigned PRM_PORTS_DEF = 3;
   localparam int unsigned PRM_STRAP_DEF = 2;

   function automatic int unsigned prm_idx_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/prm_cfg_regs.sv
module prm_cfg_regs #(
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned STRAP_PORTS = 2,
   parameter int unsigned IDX_W       = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PORTS-1:0]            strap_dis,
   input  logic [NUM_PORTS-1:0]            cfg_dis,
   input  logic [NUM_PORTS-1:0][IDX_W-1:0] cfg_order,
   output logic [NUM_PORTS-1:0]            dis_eff,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] order_q,
   output logic [IDX_W-1:0]                en_count
);
   logic [NUM_PORTS-1:0] strap_mask;
   logic [NUM_PORTS-1:0] strap_q;
   logic [NUM_PORTS-1:0] reg_dis_q;
   logic                 strap_done;

   // only the lower ports carry a strap input
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
      if (p < STRAP_PORTS) begin : g_strap
         assign strap_mask[p] = 1'b1;
      end else begin : g_fixed
         assign strap_mask[p] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_dis_q  <= '0;
         strap_q    <= '0;
         strap_done <= 1'b0;
         for (int k = 0; k < NUM_PORTS; k++) begin
            order_q[k] <= IDX_W'(k + 1);
         end
      end else begin
         reg_dis_q <= cfg_dis;
         order_q   <= cfg_order;
         if (!strap_done) begin
            strap_q    <= strap_dis & strap_mask;
            strap_done <= 1'b1;
         end
      end
   end

   assign dis_eff = reg_dis_q | strap_q;

   always_comb begin
      int c;
      c = 0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (!dis_eff[p]) c++;
      end
      en_count = IDX_W'(c);
   end

   // R7: once taken, the strap sample never moves
   assert_strap_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done |=> $stable(strap_q));
endmodule

// File: rtl/prm_order_check.sv
module prm_order_check #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [NUM_PORTS-1:0][IDX_W-1:0] order_in,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] order_eff,
   output logic                            bad
);
   always_comb begin
      logic [NUM_PORTS-1:0] seen;
      logic                 hit;
      seen = '0;
      bad  = 1'b0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         hit = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(order_in[k]) == p + 1) begin
               hit = 1'b1;
               if (seen[p]) bad = 1'b1;
               seen[p] = 1'b1;
            end
         end
         if (!hit) bad = 1'b1;
      end
      for (int k = 0; k < NUM_PORTS; k++) begin
         order_eff[k] = bad ? IDX_W'(k + 1) : order_in[k];
      end
   end
endmodule

// File: rtl/prm_pack.sv
module prm_pack #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [NUM_PORTS-1:0]            dis,
   input  logic [NUM_PORTS-1:0][IDX_W-1:0] order_eff,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] l2p,
   output logic [NUM_PORTS-1:0]            l2p_v,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] p2l,
   output logic [NUM_PORTS-1:0]            p2l_v
);
   always_comb begin
      int   cnt;
      int   ph;
      logic en;
      l2p   = '0;
      l2p_v = '0;
      p2l   = '0;
      p2l_v = '0;
      cnt   = 0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         en = 1'b0;
         ph = 0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(order_eff[k]) == p + 1) begin
               ph = p;
               en = !dis[p];
            end
         end
         if (en) begin
            for (int l = 0; l < NUM_PORTS; l++) begin
               if (l == cnt) begin
                  l2p[l]   = IDX_W'(ph + 1);
                  l2p_v[l] = 1'b1;
               end
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
               if (p == ph) begin
                  p2l[p]   = IDX_W'(cnt + 1);
                  p2l_v[p] = 1'b1;
               end
            end
            cnt++;
         end
      end
   end
endmodule

// File: rtl/port_remap_top.sv
module port_remap_top #(
   parameter int unsigned NUM_PORTS   = prm_pkg::PRM_PORTS_DEF,
   parameter int unsigned STRAP_PORTS = prm_pkg::PRM_STRAP_DEF,
   parameter int unsigned IDX_W       = prm_pkg::prm_idx_bits(NUM_PORTS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PORTS-1:0]            strap_dis,
   input  logic [NUM_PORTS-1:0]            cfg_dis,
   input  logic [NUM_PORTS-1:0][IDX_W-1:0] cfg_order,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] l2p_phys,
   output logic [NUM_PORTS-1:0]            l2p_valid,
   output logic [NUM_PORTS-1:0][IDX_W-1:0] p2l_log,
   output logic [NUM_PORTS-1:0]            p2l_valid,
   output logic [IDX_W-1:0]                active_count,
   output logic                            config_error
);
   localparam int unsigned MIN_W = prm_pkg::prm_idx_bits(NUM_PORTS);

   if (NUM_PORTS < 1 || STRAP_PORTS > NUM_PORTS || IDX_W < MIN_W) begin : g_bad_params
      $error("port_remap_top: illegal parameter set");
   end

   logic [NUM_PORTS-1:0]            dis_eff;
   logic [NUM_PORTS-1:0][IDX_W-1:0] order_q;
   logic [NUM_PORTS-1:0][IDX_W-1:0] order_eff;

   prm_cfg_regs #(.NUM_PORTS(NUM_PORTS), .STRAP_PORTS(STRAP_PORTS), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_dis (strap_dis),
      .cfg_dis   (cfg_dis),
      .cfg_order (cfg_order),
      .dis_eff   (dis_eff),
      .order_q   (order_q),
      .en_count  (active_count)
   );

   prm_order_check #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_check (
      .order_in  (order_q),
      .order_eff (order_eff),
      .bad       (config_error)
   );

   prm_pack #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pack (
      .dis       (dis_eff),
      .order_eff (order_eff),
      .l2p       (l2p_phys),
      .l2p_v     (l2p_valid),
      .p2l       (p2l_log),
      .p2l_v     (p2l_valid)
   );

   // R3: count from the disable mask agrees with the packed valid set
   assert_count_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(active_count) == $countones(p2l_valid));

   // R3: logical numbering is gap free from 1
   assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(l2p_valid) == ((1 << int'(active_count)) - 1));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      // R6: a disabled port never appears in the mapping
      assert_disabled_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
         dis_eff[p] |-> (!p2l_valid[p] && p2l_log[p] == '0));
   end

   for (genvar l = 0; l < NUM_PORTS; l++) begin : g_log_chk
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_phys_chk
         // R4: the two lookups are inverse to each other
         assert_roundtrip_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (l2p_valid[l] && l2p_phys[l] == IDX_W'(p + 1)) |->
               (p2l_valid[p] && p2l_log[p] == IDX_W'(l + 1)));
      end
      // R5: with nothing disabled, an illegal table yields identity order
      assert_fallback_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (config_error && dis_eff == '0) |-> (l2p_phys[l] == IDX_W'(l + 1)));
   end
endmodule

// File: tb/tb_port_remap_top.sv
module tb_port_remap_top;
   localparam int N = 3;
   localparam int W = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic [N-1:0]        strap_dis;
   logic [N-1:0]        cfg_dis;
   logic [N-1:0][W-1:0] cfg_order;
   logic [N-1:0][W-1:0] l2p_phys;
   logic [N-1:0]        l2p_valid;
   logic [N-1:0][W-1:0] p2l_log;
   logic [N-1:0]        p2l_valid;
   logic [W-1:0]        active_count;
   logic                config_error;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   port_remap_top dut (
      .clk(clk), .rst_n(rst_n), .strap_dis(strap_dis), .cfg_dis(cfg_dis),
      .cfg_order(cfg_order), .l2p_phys(l2p_phys), .l2p_valid(l2p_valid),
      .p2l_log(p2l_log), .p2l_valid(p2l_valid), .active_count(active_count),
      .config_error(config_error)
   );

   // {dis[2:0], order{slot2,slot1,slot0}, count, err, l2p{L3,L2,L1}, p2l{P3,P2,P1}}
   localparam int NV = 9;
   localparam logic [23:0] VEC [NV] = '{
      {3'b000, 6'b11_10_01, 2'd3, 1'b0, 6'b11_10_01, 6'b11_10_01},
      {3'b000, 6'b10_01_11, 2'd3, 1'b0, 6'b10_01_11, 6'b01_11_10},
      {3'b010, 6'b11_10_01, 2'd2, 1'b0, 6'b00_11_01, 6'b10_00_01},
      {3'b001, 6'b10_01_11, 2'd2, 1'b0, 6'b00_10_11, 6'b01_10_00},
      {3'b101, 6'b11_10_01, 2'd1, 1'b0, 6'b00_00_10, 6'b00_01_00},
      {3'b111, 6'b11_10_01, 2'd0, 1'b0, 6'b00_00_00, 6'b00_00_00},
      {3'b000, 6'b01_10_10, 2'd3, 1'b1, 6'b11_10_01, 6'b11_10_01},
      {3'b100, 6'b11_01_00, 2'd2, 1'b1, 6'b00_10_01, 6'b00_10_01},
      {3'b000, 6'b01_11_10, 2'd3, 1'b0, 6'b01_11_10, 6'b10_01_11}
   };

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 8: return "R3";
         2, 3, 4: return "R4";
         5:       return "R9";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int pv_of(input logic [5:0] p2l);
      int r;
      r = 0;
      for (int p = 0; p < N; p++) if (p2l[2*p +: 2] != 2'd0) r |= (1 << p);
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [23:0] v);
      chk(req, "active_count", int'(active_count), int'(v[14:13]));
      chk(req, "config_error", int'(config_error), int'(v[12]));
      chk(req, "l2p_phys", int'(l2p_phys), int'(v[11:6]));
      chk(req, "p2l_log", int'(p2l_log), int'(v[5:0]));
      chk(req, "l2p_valid", int'(l2p_valid), (1 << int'(v[14:13])) - 1);
      chk(req, "p2l_valid", int'(p2l_valid), pv_of(v[5:0]));
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      rst_n     = 1'b0;
      strap_dis = 3'b111;
      cfg_dis   = 3'b000;
      cfg_order = 6'b11_10_01;
      repeat (2) @(negedge clk);
      // R1: reset state while reset is held
      check_vec("R1", {3'b000, 6'b11_10_01, 2'd3, 1'b0, 6'b11_10_01, 6'b11_10_01});

      // R8: strap on port 3 ignored, ports 1 and 2 strapped off
      rst_n = 1'b1;
      @(negedge clk);
      check_vec("R8", {3'b000, 6'b11_10_01, 2'd1, 1'b0, 6'b00_00_11, 6'b01_00_00});

      // R7: strap changes after sampling have no effect
      strap_dis = 3'b000;
      repeat (2) @(negedge clk);
      check_vec("R7", {3'b000, 6'b11_10_01, 2'd1, 1'b0, 6'b00_00_11, 6'b01_00_00});

      // R6: register disable ORed with strap disables
      cfg_dis = 3'b100;
      @(negedge clk);
      check_vec("R6", {3'b000, 6'b11_10_01, 2'd0, 1'b0, 6'b00_00_00, 6'b00_00_00});

      // new reset with no straps, then the vector table
      rst_n   = 1'b0;
      cfg_dis = 3'b000;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cfg_dis   = VEC[i][23:21];
         cfg_order = VEC[i][20:15];
         #1;
         if (i > 0) begin
            // R2: outputs hold the previous setting until the edge
            chk("R2", "l2p_phys before edge", int'(l2p_phys), int'(VEC[i-1][11:6]));
            chk("R2", "count before edge", int'(active_count), int'(VEC[i-1][14:13]));
         end
         @(negedge clk);
         check_vec(tag_of(i), VEC[i]);
      end

      // R5: out-of-range and duplicate also cover a zero in the last slot
      cfg_dis   = 3'b010;
      cfg_order = 6'b00_11_01;
      @(negedge clk);
      check_vec("R5", {3'b010, 6'b00_11_01, 2'd2, 1'b1, 6'b00_11_01, 6'b10_00_01});

      finish_run();
   end
endmodule